// File: doc/BRIEF.md
# Page-Aligned Write Buffer with Idle Flush

This block sits between a byte-oriented write path and a flash programming sequencer. Bytes arrive one at a time and are collected in a single page-sized buffer. Flash is only ever given whole pages to program. Each page is programmed exactly once, and the number of partial programs is limited because a page is sent only when one of four events occurs:

- the buffer fills;
- the host raises a sync strobe;
- the host raises a shutdown strobe;
- no byte has been accepted for a programmable number of clock cycles.

When a page is sent with fewer bytes than its full length, the unused tail is filled with the erased value 0xFF. The page leaves as a byte stream with a last-byte marker, together with a page address. The block then waits for a done pulse from the sequencer. The address starts at zero and advances by one after each completed program. While a page is being sent or programmed, the write port is held off. After a shutdown request, the block flushes whatever it holds. It then parks in a stopped state and reports that it is quiescent. Only reset leaves that state.

Top module: `page_gather_buffer`

## Requirements
- R1: After reset, wr_ready is 1, pg_valid is 0, down_o is 0 and pg_addr is 0.
- R2: Writing PAGE_BYTES bytes starts a stream of exactly PAGE_BYTES beats carrying those bytes in arrival order. pg_last is 1 on the final beat only.
- R3: wr_ready is 0 from the cycle after the write that triggers a flush until the cycle after fl_done is seen.
- R4: A sync_req pulse with N bytes held (0 < N < PAGE_BYTES) sends the N bytes followed by PAGE_BYTES-N bytes of 0xFF.
- R5: A sync_req pulse with the buffer empty produces no stream, and the port stays ready.
- R6: With the buffer non-empty and no write accepted, pg_valid rises no sooner than IDLE_CYCLES and no later than IDLE_CYCLES+2 cycles after the last accepted write.
- R7: The idle count restarts on each accepted byte. Writes spaced fewer than IDLE_CYCLES cycles apart never cause a flush.
- R8: pg_addr is stable while a page is outstanding. It increases by exactly one after each fl_done that completes a program.
- R9: shut_req with data held flushes that data. After fl_done, down_o becomes 1 and stays 1, and wr_ready and pg_valid stay 0.
- R10: A shut_req that arrives while a page is being sent is remembered. The block stops after that page's fl_done.
- R11: shut_req on an empty buffer raises down_o on the next cycle with no stream.
- R12: An fl_done pulse while no page is outstanding is ignored. pg_addr and wr_ready do not change.
- R13: While pg_valid is 1 and pg_ready is 0, pg_valid, pg_data and pg_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | DATA_W | Write byte |
| wr_ready | output | 1 | Byte accepted when high with wr_valid |
| sync_req | input | 1 | Pulse: flush held bytes now |
| shut_req | input | 1 | Pulse: flush then stop |
| down_o | output | 1 | Stopped after shutdown |
| pg_valid | output | 1 | Page stream beat valid |
| pg_ready | input | 1 | Sequencer accepts beat |
| pg_data | output | DATA_W | Page byte |
| pg_last | output | 1 | Final beat of the page |
| pg_addr | output | ADDR_W | Address of the page being sent |
| fl_done | input | 1 | Pulse: program of the sent page finished |

## Verification
A wrong fill count shows up on the very next flush, in one of two ways:

- the wrong bytes are sent;
- the 0xFF padding starts at the wrong beat.

A fault in the idle counter moves the rise of pg_valid outside its window after the last write. It can also produce a flush in a stream of closely spaced writes. A lost pending shutdown appears within a cycle of fl_done, because wr_ready rises instead of down_o. A corrupt address counter is exposed on the next page as a step other than one.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
   typedef enum logic [1:0] {
      ST_FILL = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2,
      ST_STOP = 2'd3
   } pgb_state_e;

   localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/pgb_store.sv
module pgb_store #(
   parameter int unsigned PAGE_BYTES = 512,
   parameter int unsigned DATA_W     = 8,
   parameter logic [DATA_W-1:0] PAD_VALUE = '1,
   localparam int unsigned IDX_W = $clog2(PAGE_BYTES),
   localparam int unsigned CNT_W = $clog2(PAGE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clear,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CNT_W-1:0]  fill_cnt,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [PAGE_BYTES];
   logic              has_room;

   assign has_room = (fill_cnt < CNT_W'(PAGE_BYTES));

   always_ff @(posedge clk) begin
      if (wr_en && has_room)
         mem[fill_cnt[IDX_W-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         fill_cnt <= '0;
      else if (clear)
         fill_cnt <= '0;
      else if (wr_en && has_room)
         fill_cnt <= fill_cnt + 1'b1;
   end

   // bytes past the fill level read as erased
   assign rd_data = (CNT_W'(rd_idx) < fill_cnt) ? mem[rd_idx] : PAD_VALUE;
endmodule

// File: rtl/pgb_idle.sv
module pgb_idle #(
   parameter int unsigned IDLE_CYCLES = 400_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic kick,
   output logic expire
);
   generate
      if (IDLE_CYCLES == 0) begin : g_off
         assign expire = 1'b0;
      end else begin : g_on
         localparam int unsigned TW = $clog2(IDLE_CYCLES + 1);
         logic [TW-1:0] tcnt;

         always_ff @(posedge clk) begin
            if (!rst_n)
               tcnt <= '0;
            else if (kick || !arm)
               tcnt <= '0;
            else if (tcnt != TW'(IDLE_CYCLES))
               tcnt <= tcnt + 1'b1;
         end

         assign expire = arm && !kick && (tcnt == TW'(IDLE_CYCLES));
      end
   endgenerate
endmodule

// File: rtl/pgb_ctrl.sv
module pgb_ctrl
   import pgb_pkg::*;
#(
   parameter int unsigned PAGE_BYTES = 512,
   parameter int unsigned ADDR_W     = 16,
   localparam int unsigned IDX_W = $clog2(PAGE_BYTES),
   localparam int unsigned CNT_W = $clog2(PAGE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              sync_req,
   input  logic              shut_req,
   input  logic              pg_ready,
   input  logic              fl_done,
   input  logic              expire,
   input  logic [CNT_W-1:0]  fill_cnt,
   output logic              wr_ready,
   output logic              wr_en,
   output logic              clear,
   output logic              arm,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              pg_valid,
   output logic              pg_last,
   output logic [ADDR_W-1:0] pg_addr,
   output logic              down_o
);
   pgb_state_e state, state_nx;
   logic       shut_pend;
   logic       shut_any;
   logic [CNT_W-1:0] cnt_after;
   logic       want_flush;
   logic       beat_go;

   assign wr_ready   = (state == ST_FILL);
   assign wr_en      = wr_ready && wr_valid;
   assign arm        = (state == ST_FILL) && (fill_cnt != '0);
   assign pg_valid   = (state == ST_SEND);
   assign pg_last    = pg_valid && (rd_idx == IDX_W'(PAGE_BYTES - 1));
   assign down_o     = (state == ST_STOP);
   assign clear      = (state == ST_WAIT) && fl_done;
   assign shut_any   = shut_pend || shut_req;
   assign cnt_after  = fill_cnt + CNT_W'(wr_en);
   assign want_flush = (cnt_after == CNT_W'(PAGE_BYTES)) || sync_req || expire || shut_any;
   assign beat_go    = pg_valid && pg_ready;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_FILL: begin
            if (want_flush && (cnt_after != '0))
               state_nx = ST_SEND;
            else if (shut_any)
               state_nx = ST_STOP;
         end
         ST_SEND: if (beat_go && pg_last) state_nx = ST_WAIT;
         ST_WAIT: if (fl_done) state_nx = shut_any ? ST_STOP : ST_FILL;
         ST_STOP: state_nx = ST_STOP;
         default: state_nx = ST_STOP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_FILL;
         shut_pend <= 1'b0;
         rd_idx    <= '0;
         pg_addr   <= '0;
      end else begin
         state <= state_nx;
         if (shut_req && state != ST_STOP)
            shut_pend <= 1'b1;
         if (beat_go)
            rd_idx <= pg_last ? '0 : rd_idx + 1'b1;
         if (clear)
            pg_addr <= pg_addr + 1'b1;
      end
   end
endmodule

// File: rtl/page_gather_buffer.sv
module page_gather_buffer
   import pgb_pkg::*;
#(
   parameter int unsigned PAGE_BYTES  = 512,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned IDLE_CYCLES = 400_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              sync_req,
   input  logic              shut_req,
   output logic              down_o,
   output logic              pg_valid,
   input  logic              pg_ready,
   output logic [DATA_W-1:0] pg_data,
   output logic              pg_last,
   output logic [ADDR_W-1:0] pg_addr,
   input  logic              fl_done
);
   localparam int unsigned IDX_W = $clog2(PAGE_BYTES);
   localparam int unsigned CNT_W = $clog2(PAGE_BYTES + 1);

   generate
      if (PAGE_BYTES < 2) begin : g_bad_page
         initial $error("PAGE_BYTES must be at least 2");
      end
      if (DATA_W != 8) begin : g_bad_width
         initial $error("DATA_W must be 8 for the erased pad value");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         initial $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic             wr_en, clear, arm, expire;
   logic [IDX_W-1:0] rd_idx;
   logic [CNT_W-1:0] fill_cnt;

   pgb_store #(
      .PAGE_BYTES(PAGE_BYTES),
      .DATA_W    (DATA_W),
      .PAD_VALUE (DATA_W'(ERASED_BYTE))
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .clear   (clear),
      .rd_idx  (rd_idx),
      .fill_cnt(fill_cnt),
      .rd_data (pg_data)
   );

   pgb_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (arm),
      .kick  (wr_en),
      .expire(expire)
   );

   pgb_ctrl #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_valid(wr_valid),
      .sync_req(sync_req),
      .shut_req(shut_req),
      .pg_ready(pg_ready),
      .fl_done (fl_done),
      .expire  (expire),
      .fill_cnt(fill_cnt),
      .wr_ready(wr_ready),
      .wr_en   (wr_en),
      .clear   (clear),
      .arm     (arm),
      .rd_idx  (rd_idx),
      .pg_valid(pg_valid),
      .pg_last (pg_last),
      .pg_addr (pg_addr),
      .down_o  (down_o)
   );
endmodule

// File: rtl/pgb_checker.sv
module pgb_checker #(
   parameter int unsigned PAGE_BYTES = 512,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_ready,
   input logic              down_o,
   input logic              pg_valid,
   input logic              pg_ready,
   input logic [DATA_W-1:0] pg_data,
   input logic              pg_last,
   input logic [ADDR_W-1:0] pg_addr
);
   localparam int unsigned BW = $clog2(PAGE_BYTES);
   logic [BW-1:0] beat;

   always_ff @(posedge clk) begin
      if (!rst_n)
         beat <= '0;
      else if (pg_valid && pg_ready)
         beat <= pg_last ? '0 : beat + 1'b1;
   end

   p_last_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pg_valid |-> (pg_last == (beat == BW'(PAGE_BYTES - 1))));

   p_no_write_while_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pg_valid |-> !wr_ready);

   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pg_valid |-> $stable(pg_addr));

   p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_addr != $past(pg_addr)) |-> (pg_addr == $past(pg_addr) + 1'b1));

   p_down_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      down_o |=> down_o);

   p_down_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      down_o |-> (!wr_ready && !pg_valid));

   p_stream_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_valid && !pg_ready) |=> (pg_valid && $stable(pg_data) && $stable(pg_last)));
endmodule

bind page_gather_buffer pgb_checker #(
   .PAGE_BYTES(PAGE_BYTES),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W)
) u_pgb_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_ready(wr_ready),
   .down_o  (down_o),
   .pg_valid(pg_valid),
   .pg_ready(pg_ready),
   .pg_data (pg_data),
   .pg_last (pg_last),
   .pg_addr (pg_addr)
);

// File: tb/test_page_gather_buffer.sv
`timescale 1ns/1ps
module test_page_gather_buffer;
   localparam int P    = 16;
   localparam int IDLE = 40;
   localparam int AW   = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [7:0]    wr_data = '0;
   logic          wr_ready;
   logic          sync_req = 1'b0;
   logic          shut_req = 1'b0;
   logic          down_o;
   logic          pg_valid;
   logic          pg_ready = 1'b0;
   logic [7:0]    pg_data;
   logic          pg_last;
   logic [AW-1:0] pg_addr;
   logic          fl_done = 1'b0;

   int checks = 0;
   int errors = 0;
   int exp_addr = 0;
   int ncyc = 0;
   logic [7:0] exp_q [P];

   always #2.5 clk = ~clk;
   always @(posedge clk) ncyc <= ncyc + 1;

   page_gather_buffer #(
      .PAGE_BYTES(P), .DATA_W(8), .ADDR_W(AW), .IDLE_CYCLES(IDLE)
   ) i_page_gather_buffer (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .sync_req(sync_req), .shut_req(shut_req),
      .down_o(down_o), .pg_valid(pg_valid), .pg_ready(pg_ready),
      .pg_data(pg_data), .pg_last(pg_last), .pg_addr(pg_addr), .fl_done(fl_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_addr = 0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] b);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = b;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_sync();
      @(negedge clk); sync_req = 1'b1;
      @(negedge clk); sync_req = 1'b0;
   endtask

   task automatic pulse_shut();
      @(negedge clk); shut_req = 1'b1;
      @(negedge clk); shut_req = 1'b0;
   endtask

   // collects one page, compares against exp_q[0..n-1] then 0xFF, completes with fl_done
   task automatic capture(input int n, input bit shut_mid, input bit expect_stop);
      int k = 0;
      int bad = 0;
      int badlast = 0;
      int addr0;
      int first_bad_val = 0;
      int first_bad_exp = 0;
      while (!pg_valid) @(negedge clk);
      addr0 = int'(pg_addr);
      chk(addr0 == exp_addr, "R8 page address", addr0, exp_addr);
      while (k < P) begin
         pg_ready = (ncyc % 3) != 1;
         if (shut_mid && k == 2) shut_req = 1'b1; else shut_req = 1'b0;
         if (pg_valid && pg_ready) begin
            logic [7:0] e;
            e = (k < n) ? exp_q[k] : 8'hFF;
            if (pg_data !== e && bad == 0) begin
               first_bad_val = int'(pg_data);
               first_bad_exp = int'(e);
            end
            if (pg_data !== e) bad++;
            if (pg_last !== (k == P - 1)) badlast++;
            k++;
         end
         @(negedge clk);
      end
      pg_ready = 1'b0;
      shut_req = 1'b0;
      chk(bad == 0, (n < P) ? "R4 page bytes with pad" : "R2 page bytes", first_bad_val, first_bad_exp);
      chk(badlast == 0, "R2 last marker position", badlast, 0);
      repeat (3) @(negedge clk);
      chk(wr_ready == 1'b0 && pg_valid == 1'b0, "R3 port held while programming", int'(wr_ready), 0);
      chk(int'(pg_addr) == exp_addr, "R8 address stable before done", int'(pg_addr), exp_addr);
      fl_done = 1'b1;
      @(negedge clk);
      fl_done = 1'b0;
      exp_addr++;
      chk(int'(pg_addr) == exp_addr, "R8 address step", int'(pg_addr), exp_addr);
      if (expect_stop) begin
         chk(down_o == 1'b1 && wr_ready == 1'b0, "R9 stopped after final program", int'(down_o), 1);
      end else begin
         chk(wr_ready == 1'b1 && down_o == 1'b0, "R3 port ready after done", int'(wr_ready), 1);
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk(wr_ready == 1'b1, "R1 reset wr_ready", int'(wr_ready), 1);
      chk(pg_valid == 1'b0, "R1 reset pg_valid", int'(pg_valid), 0);
      chk(down_o == 1'b0, "R1 reset down_o", int'(down_o), 0);
      chk(pg_addr == '0, "R1 reset pg_addr", int'(pg_addr), 0);
   endtask

   task automatic t_sync_empty();
      int seen = 0;
      pulse_sync();
      repeat (IDLE + 5) begin
         if (pg_valid) seen++;
         @(negedge clk);
      end
      chk(seen == 0, "R5 sync on empty sends nothing", seen, 0);
      chk(wr_ready == 1'b1, "R5 still ready", int'(wr_ready), 1);
   endtask

   task automatic t_sync_partial();
      for (int i = 0; i < 5; i++) begin
         exp_q[i] = 8'(8'h30 + i);
         wr(exp_q[i]);
      end
      pulse_sync();
      capture(5, 1'b0, 1'b0);
   endtask

   task automatic t_full_page();
      for (int i = 0; i < P; i++) begin
         exp_q[i] = 8'(i * 7 + 1);
         wr(exp_q[i]);
      end
      chk(wr_ready == 1'b0, "R3 held after page-completing write", int'(wr_ready), 0);
      capture(P, 1'b0, 1'b0);
   endtask

   task automatic t_idle();
      int c = 0;
      for (int i = 0; i < 3; i++) begin
         exp_q[i] = 8'(8'hA0 + i);
         wr(exp_q[i]);
      end
      while (!pg_valid && c < IDLE + 10) begin
         @(negedge clk);
         c++;
      end
      chk(c >= IDLE && c <= IDLE + 2, "R6 idle flush delay", c, IDLE + 1);
      capture(3, 1'b0, 1'b0);
   endtask

   task automatic t_restart();
      int seen = 0;
      for (int i = 0; i < 4; i++) begin
         exp_q[i] = 8'(8'h55 ^ i);
         wr(exp_q[i]);
         repeat (IDLE - 10) begin
            if (pg_valid) seen++;
            @(negedge clk);
         end
      end
      chk(seen == 0, "R7 spaced writes cause no flush", seen, 0);
      pulse_sync();
      capture(4, 1'b0, 1'b0);
   endtask

   task automatic t_stray_done();
      @(negedge clk); fl_done = 1'b1;
      @(negedge clk); fl_done = 1'b0;
      @(negedge clk);
      chk(int'(pg_addr) == exp_addr, "R12 stray done keeps address", int'(pg_addr), exp_addr);
      chk(wr_ready == 1'b1 && pg_valid == 1'b0, "R12 stray done keeps state", int'(wr_ready), 1);
   endtask

   task automatic t_shut_mid();
      for (int i = 0; i < P; i++) begin
         exp_q[i] = 8'(8'hF0 - i);
         wr(exp_q[i]);
      end
      capture(P, 1'b1, 1'b1);
      repeat (IDLE + 4) @(negedge clk);
      chk(down_o == 1'b1 && wr_ready == 1'b0, "R10 pending shutdown honoured", int'(down_o), 1);
   endtask

   task automatic t_shut_data();
      for (int i = 0; i < 6; i++) begin
         exp_q[i] = 8'(8'h11 * (i + 1));
         wr(exp_q[i]);
      end
      pulse_shut();
      capture(6, 1'b0, 1'b1);
      pulse_sync();
      repeat (5) @(negedge clk);
      chk(down_o == 1'b1 && pg_valid == 1'b0 && wr_ready == 1'b0, "R9 stays stopped", int'(down_o), 1);
   endtask

   task automatic t_shut_empty();
      @(negedge clk); shut_req = 1'b1;
      @(negedge clk); shut_req = 1'b0;
      chk(down_o == 1'b1, "R11 empty shutdown stops next cycle", int'(down_o), 1);
      chk(pg_valid == 1'b0 && int'(pg_addr) == exp_addr, "R11 no stream", int'(pg_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_sync_empty();
      t_sync_partial();
      t_full_page();
      t_idle();
      t_restart();
      t_stray_done();
      t_shut_mid();
      do_reset();
      t_shut_data();
      do_reset();
      t_shut_empty();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule